// File: doc/BRIEF.md
# Polled Power-Cap Mailbox Engine

The engine serves a command/response mailbox that lives in a shared, byte-addressed memory. A host places a command in a command buffer and raises its ready flag. The engine looks at the mailbox only when its `tick` input pulses; that pulse comes from an external programmable period counter. One opcode is executed: setting a power cap. Before any result is published, the engine passes through a mandatory in-progress handshake. Any other opcode, a bad length or a corrupted response flag produces an error status.

The engine owns a single synchronous memory port that moves one byte per cycle. Read data returns one cycle after the request. Each poll works in three phases:
- it fetches every byte it may need;
- it decides the outcome in one cycle;
- it writes a fixed sequence of byte slots.

The response payload is written before the flags. A one-cycle interrupt pulse closes each completed response. After reset, the engine also writes the default state and cap values into the shared area.

Top module: `pwrcap_mbox_engine`

## Requirements
- R1: After reset the engine writes the shared area at byte offsets 0..9: run state 0x03 at 0, cap type 0x00 at 1, and four 16-bit big-endian values (high byte first). These are hard minimum 10 at 2..3, maximum 100 at 4..5, current cap 100 at 6..7 and soft minimum 20 at 8..9.
- R2: A poll acts only when the command flag (offset 16) reads exactly 0x80. Any other value, for example 0x00 or 0x81, leads to no memory write and no interrupt.
- R3: If a command is pending and the response flag (offset 32) is 0x00, the poll's only write is 0x02 to the response flag, with no interrupt.
- R4: If a command is pending and the response flag is neither 0x00 nor 0x02, the engine answers with status 0x15 and length 0.
- R5: For opcode 0xD1 (offset 18) whose big-endian length (offsets 20..21) is not 2, the engine answers with status 0x12, length 2 and the current cap bytes (offsets 6..7), and leaves the cap unchanged.
- R6: For opcode 0xD1, a requested cap (offsets 22..23, big-endian) of 0 writes cap type 0x00 and current cap 100.
- R7: For opcode 0xD1, a nonzero request writes cap type 0x02 and a current cap clamped to 10..100. The answer is status 0x00, length 2 and the new cap as data.
- R8: Any other opcode gets status 0x11 and length 0.
- R9: A response writes the following bytes, one per cycle in this order, skipping absent items:
  - cap type (1) and current cap (6, 7), on a cap update only;
  - request id (33, copied from 17) and opcode (34, copied from 18);
  - status (35) and length (36, 37);
  - data (38, 39), when the length is 2;
  - response flag 0x01 (32), then command flag 0x00 (16).

  In the cycle after these writes, `irq` is high for exactly one cycle.
- R10: A `tick` that arrives while a poll or the reset initialisation is in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Poll request pulse from the period counter |
| mem_en | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read request |
| irq | output | 1 | One-cycle message interrupt |

## Verification
The assertions check the following on every cycle:
- the response flag only ever receives 0x01 or 0x02;
- the cap type only ever receives 0x00 or 0x02;
- a written current cap always lies in the clamp window;
- the command flag is cleared only right after the response flag is set;
- `irq` is a single-cycle pulse that directly follows that release.

Only the bench scenarios can show the rest. That covers the exact payload bytes and their order, the copied id and opcode, and the per-case status codes. It also covers the two-tick handshake, the unchanged cap after a length error, and the dropping of ticks that arrive while the engine is busy.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int FETCH_N = 10;
  localparam int SLOT_N  = 12;
  localparam int INIT_N  = 10;
  localparam int CNT_W   = 4;

  localparam logic [7:0] CMD_READY  = 8'h80;
  localparam logic [7:0] RSP_DONE   = 8'h01;
  localparam logic [7:0] RSP_BUSY   = 8'h02;
  localparam logic [7:0] ST_OK      = 8'h00;
  localparam logic [7:0] ST_BADOP   = 8'h11;
  localparam logic [7:0] ST_BADLEN  = 8'h12;
  localparam logic [7:0] ST_INTERR  = 8'h15;
  localparam logic [7:0] OP_SETCAP  = 8'hD1;
  localparam logic [7:0] CAPT_NONE  = 8'h00;
  localparam logic [7:0] CAPT_USER  = 8'h02;
  localparam logic [7:0] RUN_ACTIVE = 8'h03;

  // offsets inside the shared-state area
  localparam int OFS_STATE = 0, OFS_CAPTYPE = 1, OFS_HMIN = 2, OFS_MAX = 4;
  localparam int OFS_CUR = 6, OFS_SMIN = 8;
  // offsets inside the command and response buffers
  localparam int OFS_FLAG = 0, OFS_ID = 1, OFS_OP = 2, OFS_STAT = 3;
  localparam int OFS_LEN = 4, OFS_DATA = 6;

  // index of each fetched byte
  localparam int FI_CFLAG = 0, FI_RFLAG = 1, FI_ID = 2, FI_OP = 3, FI_LENH = 4;
  localparam int FI_LENL = 5, FI_DH = 6, FI_DL = 7, FI_CAPH = 8, FI_CAPL = 9;

  // write slots, in issue order
  localparam int SL_CAPTYPE = 0, SL_CURH = 1, SL_CURL = 2, SL_RID = 3, SL_ROP = 4;
  localparam int SL_RST = 5, SL_RLENH = 6, SL_RLENL = 7, SL_RD0 = 8, SL_RD1 = 9;
  localparam int SL_RFLAG = 10, SL_CFLAG = 11;

  typedef enum logic [2:0] {
    FS_BOOT, FS_INIT, FS_IDLE, FS_FETCH, FS_DECIDE, FS_WRITE, FS_IRQ
  } fsm_e;

  typedef enum logic [1:0] {ACT_NONE, ACT_BUSY, ACT_RESPOND} act_e;

  typedef struct packed {
    act_e              act;
    logic [SLOT_N-1:0] mask;
    logic [7:0]        status;
    logic [7:0]        len_lo;
    logic [15:0]       data;
    logic [7:0]        captype;
    logic [7:0]        rflag;
  } plan_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int CAP_MAX      = 100,
  parameter int CAP_HARD_MIN = 10
) (
  input  logic [FETCH_N*8-1:0] fbytes,
  output plan_t                plan
);
  localparam logic [15:0] CMAX = 16'(CAP_MAX);
  localparam logic [15:0] CMIN = 16'(CAP_HARD_MIN);

  logic [7:0]  cflag, rflag, opc;
  logic [15:0] req_len, req_cap, cur_cap, clamped;

  assign cflag   = fbytes[FI_CFLAG*8 +: 8];
  assign rflag   = fbytes[FI_RFLAG*8 +: 8];
  assign opc     = fbytes[FI_OP*8 +: 8];
  assign req_len = {fbytes[FI_LENH*8 +: 8], fbytes[FI_LENL*8 +: 8]};
  assign req_cap = {fbytes[FI_DH*8 +: 8], fbytes[FI_DL*8 +: 8]};
  assign cur_cap = {fbytes[FI_CAPH*8 +: 8], fbytes[FI_CAPL*8 +: 8]};
  assign clamped = (req_cap < CMIN) ? CMIN : ((req_cap > CMAX) ? CMAX : req_cap);

  always_comb begin
    plan = '0;
    plan.act = ACT_NONE;
    if (cflag == CMD_READY) begin
      if (rflag == 8'h00) begin
        plan.act            = ACT_BUSY;
        plan.rflag          = RSP_BUSY;
        plan.mask[SL_RFLAG] = 1'b1;
      end else begin
        plan.act   = ACT_RESPOND;
        plan.rflag = RSP_DONE;
        plan.mask[SL_RID]   = 1'b1;
        plan.mask[SL_ROP]   = 1'b1;
        plan.mask[SL_RST]   = 1'b1;
        plan.mask[SL_RLENH] = 1'b1;
        plan.mask[SL_RLENL] = 1'b1;
        plan.mask[SL_RFLAG] = 1'b1;
        plan.mask[SL_CFLAG] = 1'b1;
        if (rflag != RSP_BUSY) begin
          plan.status = ST_INTERR;
        end else if (opc != OP_SETCAP) begin
          plan.status = ST_BADOP;
        end else begin
          plan.len_lo      = 8'd2;
          plan.mask[SL_RD0] = 1'b1;
          plan.mask[SL_RD1] = 1'b1;
          if (req_len != 16'd2) begin
            plan.status = ST_BADLEN;
            plan.data   = cur_cap;
          end else begin
            plan.status            = ST_OK;
            plan.mask[SL_CAPTYPE]  = 1'b1;
            plan.mask[SL_CURH]     = 1'b1;
            plan.mask[SL_CURL]     = 1'b1;
            if (req_cap == 16'd0) begin
              plan.captype = CAPT_NONE;
              plan.data    = CMAX;
            end else begin
              plan.captype = CAPT_USER;
              plan.data    = clamped;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mbx_slot_map.sv
module mbx_slot_map
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DYN_BASE = 0,
  parameter int CMD_BASE = 16,
  parameter int RSP_BASE = 32
) (
  input  logic [CNT_W-1:0]  slot,
  input  plan_t             plan,
  input  logic [7:0]        req_id,
  input  logic [7:0]        req_op,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);
  always_comb begin
    addr = '0;
    data = '0;
    case (int'(slot))
      SL_CAPTYPE: begin addr = ADDR_W'(DYN_BASE + OFS_CAPTYPE);  data = plan.captype;    end
      SL_CURH:    begin addr = ADDR_W'(DYN_BASE + OFS_CUR);      data = plan.data[15:8]; end
      SL_CURL:    begin addr = ADDR_W'(DYN_BASE + OFS_CUR + 1);  data = plan.data[7:0];  end
      SL_RID:     begin addr = ADDR_W'(RSP_BASE + OFS_ID);       data = req_id;          end
      SL_ROP:     begin addr = ADDR_W'(RSP_BASE + OFS_OP);       data = req_op;          end
      SL_RST:     begin addr = ADDR_W'(RSP_BASE + OFS_STAT);     data = plan.status;     end
      SL_RLENH:   begin addr = ADDR_W'(RSP_BASE + OFS_LEN);      data = 8'h00;           end
      SL_RLENL:   begin addr = ADDR_W'(RSP_BASE + OFS_LEN + 1);  data = plan.len_lo;     end
      SL_RD0:     begin addr = ADDR_W'(RSP_BASE + OFS_DATA);     data = plan.data[15:8]; end
      SL_RD1:     begin addr = ADDR_W'(RSP_BASE + OFS_DATA + 1); data = plan.data[7:0];  end
      SL_RFLAG:   begin addr = ADDR_W'(RSP_BASE + OFS_FLAG);     data = plan.rflag;      end
      SL_CFLAG:   begin addr = ADDR_W'(CMD_BASE + OFS_FLAG);     data = 8'h00;           end
      default:    begin addr = '0;                               data = 8'h00;           end
    endcase
  end
endmodule

// File: rtl/pwrcap_mbox_engine.sv
module pwrcap_mbox_engine
  import mbx_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DYN_BASE     = 0,
  parameter int CMD_BASE     = 16,
  parameter int RSP_BASE     = 32,
  parameter int CAP_MAX      = 100,
  parameter int CAP_HARD_MIN = 10,
  parameter int CAP_SOFT_MIN = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              irq
);
  localparam logic [15:0] V_MAX  = 16'(CAP_MAX);
  localparam logic [15:0] V_HMIN = 16'(CAP_HARD_MIN);
  localparam logic [15:0] V_SMIN = 16'(CAP_SOFT_MIN);
  localparam logic [CNT_W-1:0] FETCH_END = CNT_W'(FETCH_N);
  localparam logic [CNT_W-1:0] INIT_END  = CNT_W'(INIT_N - 1);
  localparam logic [CNT_W-1:0] SLOT_END  = CNT_W'(SLOT_N - 1);

  fsm_e                 state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FETCH_N*8-1:0] fbuf_q;
  logic                 cap_en;
  logic [CNT_W-1:0]     cap_idx;
  plan_t                plan;
  logic [ADDR_W-1:0]    slot_addr;
  logic [7:0]           slot_data;

  function automatic logic [ADDR_W-1:0] fetch_addr(input logic [CNT_W-1:0] k);
    case (int'(k))
      FI_CFLAG: return ADDR_W'(CMD_BASE + OFS_FLAG);
      FI_RFLAG: return ADDR_W'(RSP_BASE + OFS_FLAG);
      FI_ID:    return ADDR_W'(CMD_BASE + OFS_ID);
      FI_OP:    return ADDR_W'(CMD_BASE + OFS_OP);
      FI_LENH:  return ADDR_W'(CMD_BASE + OFS_LEN);
      FI_LENL:  return ADDR_W'(CMD_BASE + OFS_LEN + 1);
      FI_DH:    return ADDR_W'(CMD_BASE + OFS_DATA);
      FI_DL:    return ADDR_W'(CMD_BASE + OFS_DATA + 1);
      FI_CAPH:  return ADDR_W'(DYN_BASE + OFS_CUR);
      FI_CAPL:  return ADDR_W'(DYN_BASE + OFS_CUR + 1);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [7:0] init_byte(input logic [CNT_W-1:0] k);
    case (int'(k))
      OFS_STATE:    return RUN_ACTIVE;
      OFS_CAPTYPE:  return CAPT_NONE;
      OFS_HMIN:     return V_HMIN[15:8];
      OFS_HMIN + 1: return V_HMIN[7:0];
      OFS_MAX:      return V_MAX[15:8];
      OFS_MAX + 1:  return V_MAX[7:0];
      OFS_CUR:      return V_MAX[15:8];
      OFS_CUR + 1:  return V_MAX[7:0];
      OFS_SMIN:     return V_SMIN[15:8];
      OFS_SMIN + 1: return V_SMIN[7:0];
      default:      return 8'h00;
    endcase
  endfunction

  mbx_decode #(.CAP_MAX(CAP_MAX), .CAP_HARD_MIN(CAP_HARD_MIN)) decode_i (
    .fbytes (fbuf_q),
    .plan   (plan)
  );

  mbx_slot_map #(
    .ADDR_W(ADDR_W), .DYN_BASE(DYN_BASE), .CMD_BASE(CMD_BASE), .RSP_BASE(RSP_BASE)
  ) slot_i (
    .slot   (cnt_q),
    .plan   (plan),
    .req_id (fbuf_q[FI_ID*8 +: 8]),
    .req_op (fbuf_q[FI_OP*8 +: 8]),
    .addr   (slot_addr),
    .data   (slot_data)
  );

  assign cap_idx = cnt_q - 1'b1;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cap_en    = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    irq       = 1'b0;
    case (state_q)
      FS_BOOT: begin
        state_d = FS_INIT;
        cnt_d   = '0;
      end
      FS_INIT: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ADDR_W'(DYN_BASE) + ADDR_W'(cnt_q);
        mem_wdata = init_byte(cnt_q);
        if (cnt_q == INIT_END) begin
          state_d = FS_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FS_IDLE: begin
        if (tick) begin
          state_d = FS_FETCH;
          cnt_d   = '0;
        end
      end
      FS_FETCH: begin
        if (cnt_q < FETCH_END) begin
          mem_en   = 1'b1;
          mem_addr = fetch_addr(cnt_q);
        end
        cap_en = (cnt_q != '0);
        if (cnt_q == FETCH_END) begin
          state_d = FS_DECIDE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FS_DECIDE: begin
        state_d = (plan.act == ACT_NONE) ? FS_IDLE : FS_WRITE;
        cnt_d   = '0;
      end
      FS_WRITE: begin
        mem_en    = plan.mask[cnt_q];
        mem_we    = 1'b1;
        mem_addr  = slot_addr;
        mem_wdata = slot_data;
        if (cnt_q == SLOT_END) begin
          state_d = (plan.act == ACT_RESPOND) ? FS_IRQ : FS_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FS_IRQ: begin
        irq     = 1'b1;
        state_d = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_BOOT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbuf_q <= '0;
    end else if (cap_en) begin
      fbuf_q[int'(cap_idx)*8 +: 8] <= mem_rdata;
    end
  end
endmodule

// File: rtl/pwrcap_mbox_chk.sv
module pwrcap_mbox_chk
  import mbx_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DYN_BASE     = 0,
  parameter int CMD_BASE     = 16,
  parameter int RSP_BASE     = 32,
  parameter int CAP_MAX      = 100,
  parameter int CAP_HARD_MIN = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] A_CFLAG = ADDR_W'(CMD_BASE + OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_RFLAG = ADDR_W'(RSP_BASE + OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_CTYPE = ADDR_W'(DYN_BASE + OFS_CAPTYPE);
  localparam logic [ADDR_W-1:0] A_CURH  = ADDR_W'(DYN_BASE + OFS_CUR);
  localparam logic [ADDR_W-1:0] A_CURL  = ADDR_W'(DYN_BASE + OFS_CUR + 1);
  localparam logic [7:0] LO = 8'(CAP_HARD_MIN);
  localparam logic [7:0] HI = 8'(CAP_MAX);

  logic wr;
  assign wr = mem_en && mem_we;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9
  AST_IRQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr && mem_addr == A_CFLAG && mem_wdata == 8'h00)); // R9
  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mem_addr == A_CFLAG) |-> (mem_wdata == 8'h00 &&
      $past(wr && mem_addr == A_RFLAG && mem_wdata == RSP_DONE))); // R9
  AST_RFLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mem_addr == A_RFLAG) |-> (mem_wdata == RSP_DONE || mem_wdata == RSP_BUSY)); // R3
  AST_CAPTYPE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mem_addr == A_CTYPE) |-> (mem_wdata == CAPT_NONE || mem_wdata == CAPT_USER)); // R6
  AST_CAP_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mem_addr == A_CURH) |-> mem_wdata == 8'h00); // R7
  AST_CAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mem_addr == A_CURL) |-> (mem_wdata >= LO && mem_wdata <= HI)); // R7
endmodule

bind pwrcap_mbox_engine pwrcap_mbox_chk #(
  .ADDR_W(ADDR_W), .DYN_BASE(DYN_BASE), .CMD_BASE(CMD_BASE), .RSP_BASE(RSP_BASE),
  .CAP_MAX(CAP_MAX), .CAP_HARD_MIN(CAP_HARD_MIN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
);

// File: tb/pwrcap_mbox_engine_tb_top.sv
module pwrcap_mbox_engine_tb_top;
  localparam int CFLAG = 16, CID = 17, COP = 18, CLENH = 20, CLENL = 21, CD0 = 22, CD1 = 23;
  localparam int RFLAG = 32, RID = 33, ROP = 34, RST = 35, RLENH = 36, RLENL = 37;
  localparam int RD0 = 38, RD1 = 39, CTYPE = 1, CURH = 6, CURL = 7, IRQ_EV = 999;

  typedef struct { int a; int d; string r; } ev_t;
  ev_t exp_q[$];
  int n_checks = 0, n_fail = 0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       mem_en, mem_we, irq;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       h_we = 1'b0;
  logic [7:0] h_addr = '0, h_data = '0;
  logic [7:0] mem [0:255];

  always #5 clk = ~clk;

  pwrcap_mbox_engine dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (h_we) mem[h_addr] <= h_data;
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string req, input string what, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(input int a, input int d, input string r);
    ev_t e;
    e.a = a; e.d = d; e.r = r;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int a, input int d);
    ev_t e;
    if (exp_q.size() == 0) begin
      check("R2", "unexpected event addr", a, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.r, "event addr", a, e.a);
      check(e.r, "event data", d, e.d);
    end
  endtask

  // monitor: compares each produced write/interrupt with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en && mem_we) observe(int'(mem_addr), int'(mem_wdata));
      if (irq) observe(IRQ_EV, 0);
    end
  end

  task automatic hw(input int a, input int d);
    @(negedge clk);
    h_we = 1'b1; h_addr = 8'(a); h_data = 8'(d);
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic settle(input string req);
    repeat (40) @(negedge clk);
    check(req, "pending expected events", exp_q.size(), 0);
  endtask

  task automatic post(input int id, input int op, input int len, input int req, input int rf, input int cf);
    hw(CID, id); hw(COP, op); hw(CLENH, len >> 8); hw(CLENL, len & 255);
    hw(CD0, req >> 8); hw(CD1, req & 255); hw(RFLAG, rf); hw(CFLAG, cf);
  endtask

  task automatic exp_resp(input int id, input int op, input int st, input bit capw,
                          input int ctype, input int capv, input bit dat, input int dv, input string r);
    if (capw) begin
      push(CTYPE, ctype, r); push(CURH, capv >> 8, r); push(CURL, capv & 255, r);
    end
    push(RID, id, "R9"); push(ROP, op, "R9"); push(RST, st, r);
    push(RLENH, 0, r); push(RLENL, dat ? 2 : 0, r);
    if (dat) begin
      push(RD0, dv >> 8, r); push(RD1, dv & 255, r);
    end
    push(RFLAG, 1, "R9"); push(CFLAG, 0, "R9"); push(IRQ_EV, 0, "R9");
  endtask

  // driver: full two-tick handshake for a command
  task automatic run_cmd(input int id, input int op, input int len, input int req, input int st,
                         input bit capw, input int ctype, input int capv, input bit dat,
                         input int dv, input string r);
    post(id, op, len, req, 0, 8'h80);
    push(RFLAG, 2, "R3");
    pulse_tick();
    settle("R3");
    check("R3", "cmd flag still set after busy tick", int'(mem[CFLAG]), 8'h80);
    exp_resp(id, op, st, capw, ctype, capv, dat, dv, r);
    pulse_tick();
    settle(r);
    check("R9", "cmd flag released", int'(mem[CFLAG]), 0);
    check("R9", "rsp flag done", int'(mem[RFLAG]), 1);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset initialisation writes
    push(0, 8'h03, "R1"); push(1, 0, "R1"); push(2, 0, "R1"); push(3, 10, "R1");
    push(4, 0, "R1"); push(5, 100, "R1"); push(6, 0, "R1"); push(7, 100, "R1");
    push(8, 0, "R1"); push(9, 20, "R1");
    repeat (3) @(negedge clk);
    check("R1", "irq low in reset", int'(irq), 0);
    check("R1", "mem_en low in reset", int'(mem_en), 0);
    rst_n = 1'b1;
    pulse_tick(); // R10: arrives during initialisation, dropped
    settle("R1");
    check("R1", "current cap low byte", int'(mem[CURL]), 100);
    check("R1", "soft min low byte", int'(mem[9]), 20);

    // R2: not ready flags
    post(1, 8'hD1, 2, 50, 0, 8'h00);
    pulse_tick(); settle("R2");
    check("R2", "rsp flag untouched (0x00)", int'(mem[RFLAG]), 0);
    hw(CFLAG, 8'h81);
    pulse_tick(); settle("R2");
    check("R2", "rsp flag untouched (0x81)", int'(mem[RFLAG]), 0);

    // R7: in-window and clamped requests
    run_cmd(8'h5A, 8'hD1, 2, 50, 0, 1, 2, 50, 1, 50, "R7");
    run_cmd(8'h11, 8'hD1, 2, 5, 0, 1, 2, 10, 1, 10, "R7");
    run_cmd(8'h22, 8'hD1, 2, 500, 0, 1, 2, 100, 1, 100, "R7");
    // R6: zero clears
    run_cmd(8'h33, 8'hD1, 2, 0, 0, 1, 0, 100, 1, 100, "R6");
    run_cmd(8'h44, 8'hD1, 2, 50, 0, 1, 2, 50, 1, 50, "R7");
    // R5: bad length returns current cap, cap unchanged
    run_cmd(8'h55, 8'hD1, 3, 90, 8'h12, 0, 0, 0, 1, 50, "R5");
    check("R5", "cap unchanged", int'(mem[CURL]), 50);
    run_cmd(8'h56, 8'hD1, 16'h0102, 90, 8'h12, 0, 0, 0, 1, 50, "R5");
    // R8: unknown opcode
    run_cmd(8'h66, 8'h42, 2, 70, 8'h11, 0, 0, 0, 0, 0, "R8");
    check("R8", "cap unchanged", int'(mem[CURL]), 50);

    // R4: corrupted response flag, plus R10 tick during busy poll
    post(8'h77, 8'hD1, 2, 60, 8'h07, 8'h80);
    exp_resp(8'h77, 8'hD1, 8'h15, 0, 0, 0, 0, 0, "R4");
    pulse_tick();
    repeat (3) @(negedge clk);
    pulse_tick(); // R10: dropped
    settle("R4");
    check("R4", "cap unchanged", int'(mem[CURL]), 50);

    // R10: second tick during the busy-phase poll must not trigger a response
    post(8'h88, 8'hD1, 2, 30, 0, 8'h80);
    push(RFLAG, 2, "R10");
    pulse_tick();
    repeat (4) @(negedge clk);
    pulse_tick();
    settle("R10");
    check("R10", "cmd flag still pending", int'(mem[CFLAG]), 8'h80);
    check("R10", "rsp flag busy", int'(mem[RFLAG]), 2);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule